// File: doc/BRIEF.md
# Second-Aligned Periodic Pulse Generator

This block drives up to three periodic pulse outputs from the time base's compensated nanosecond tick. Each generator holds a programmable interval in nanoseconds. On every tick it subtracts the timer period, which is the number of nanoseconds one tick advances the clock. When the remaining count falls to the period or below, the generator emits a one-clock pulse and reloads.

Generators can be held back until the first alarm strobe. Software places that alarm one timer period before a whole second, so the first pulse lands exactly on the second. Later alarm strobes re-align all generators unless realignment is disabled. The first two pulse outputs can replace the external trigger inputs, which loops them back into the trigger path. Each pulse is also reported as an event bit in a fixed position of an 8-bit field for the neighbouring event register.

Each generator is a three-state machine:
- WAIT: idle, waiting for start.
- PRIME: aligned, and the first pulse fires on the next tick.
- RUN: counting down.

Transitions:
- WAIT→PRIME (start): taken when enabled and either the alarm strobe arrives or start-on-alarm is clear.
- PRIME→RUN (first pulse): taken on a tick.
- RUN→PRIME (realign): taken on an alarm while realignment is allowed.
- any→WAIT (disable): taken when the timer is disabled.

Top module: `ppg_top`

## Requirements
- R1: After reset all pulse outputs and event bits are 0 and every generator is in WAIT.
- R2: With start-on-alarm set, a generator in WAIT produces no pulse on ticks until an alarm strobe has been seen.
- R3: With start-on-alarm clear, an enabled generator leaves WAIT on the first enabled cycle, and its first pulse follows the next tick.
- R4: In PRIME the next tick pulses and loads the interval. In RUN a tick pulses and reloads when the remaining count is ≤ the period, and otherwise subtracts the period. With an interval that is a multiple of the period, pulses are therefore interval/period ticks apart.
- R5: A pulse is high for exactly one clock, in the cycle after the tick that caused it.
- R6: An alarm while enabled with realignment allowed puts every running generator back in PRIME. A tick in the same cycle as that alarm produces no pulse.
- R7: With realignment disabled, an alarm has no effect on running generators, and a tick in that cycle is counted normally.
- R8: A new interval value takes effect at the next reload or alignment, not in the count already running.
- R9: While the timer is disabled there are no pulses and generators return to WAIT. On re-enable with start-on-alarm set they wait for an alarm again.
- R10: Event field: the pulse of generator 0 appears on bit 7, generator 1 on bit 6 and generator 2 on bit 5, in the same cycle as the pulse. Bits 4..0 are 0.
- R11: Trigger output k (k = 0, 1) equals pulse k when loop-back bit k is set, and otherwise equals external trigger input k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Compensated nanosecond-counter tick |
| alarm1_i | input | 1 | Alarm 1 match strobe |
| period_i | input | PW | Timer period in ns per tick |
| timer_en_i | input | 1 | Timer enable |
| start_on_alarm_i | input | 1 | Hold generators until alarm 1 |
| realign_dis_i | input | 1 | Disable realignment on later alarms |
| loop_en_i | input | 2 | Loop pulse 0/1 into trigger path |
| ext_trig_i | input | 2 | External trigger inputs |
| interval_i | input | NGEN*CW | Interval per generator, generator k in bits [k*CW +: CW] |
| pulse_o | output | NGEN | Pulse outputs |
| evt_o | output | 8 | Event field for the event register |
| trig_o | output | 2 | Trigger path after loop-back selection |

## Verification
The bench builds the block with all three generators (NGEN=3), 32-bit intervals and a 10-bit period. The period is set to 4 and the intervals to 12, 8 and 20, so the three generators pulse every 3, 2 and 5 ticks. This puts their pulses in different cycles, so coincidences and separations both show up within a few dozen cycles.

A short interval of 4 is written mid-run. This makes a generator pulse on every tick and exposes the reload point of an interval change. Having all three generators present also exercises every position of the event field.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

    typedef enum logic [1:0] {
        GEN_WAIT  = 2'd0,
        GEN_PRIME = 2'd1,
        GEN_RUN   = 2'd2
    } gen_state_t;

    // event field: generator k reports on bit EVT_TOP-k
    localparam int EVT_W   = 8;
    localparam int EVT_TOP = 7;
    localparam int N_LOOP  = 2;

endpackage

// File: rtl/ppg_chan.sv
module ppg_chan
    import ppg_pkg::*;
#(
    parameter int CW = 32,
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          start_go,
    input  logic          realign_go,
    input  logic [PW-1:0] period,
    input  logic [CW-1:0] interval,
    output logic          pulse
);

    localparam int ZW = CW - PW;

    gen_state_t    state_q;
    gen_state_t    state_d;
    logic [CW-1:0] rem_q;
    logic [CW-1:0] period_ext;

    assign period_ext = {{ZW{1'b0}}, period};

    // next state
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = GEN_WAIT;
        end else begin
            unique case (state_q)
                GEN_WAIT:  if (start_go)   state_d = GEN_PRIME;
                GEN_PRIME: if (!realign_go && tick) state_d = GEN_RUN;
                GEN_RUN:   if (realign_go) state_d = GEN_PRIME;
                default:   state_d = GEN_WAIT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_WAIT;
        else        state_q <= state_d;
    end

    // outputs and down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            rem_q <= '0;
        end else begin
            pulse <= 1'b0;
            if (!en) begin
                rem_q <= '0;
            end else begin
                unique case (state_q)
                    GEN_WAIT: rem_q <= '0;
                    GEN_PRIME: begin
                        if (!realign_go && tick) begin
                            pulse <= 1'b1;
                            rem_q <= interval;
                        end
                    end
                    GEN_RUN: begin
                        if (!realign_go && tick) begin
                            if (rem_q <= period_ext) begin
                                pulse <= 1'b1;
                                rem_q <= interval;
                            end else begin
                                rem_q <= rem_q - period_ext;
                            end
                        end
                    end
                    default: rem_q <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/ppg_evtmap.sv
module ppg_evtmap
    import ppg_pkg::*;
#(
    parameter int NGEN = 3
) (
    input  logic [NGEN-1:0]  pulse,
    output logic [EVT_W-1:0] evt
);

    for (genvar b = 0; b < EVT_W; b++) begin : g_bit
        if ((b <= EVT_TOP) && (EVT_TOP - b < NGEN)) begin : g_used
            assign evt[b] = pulse[EVT_TOP-b];
        end else begin : g_zero
            assign evt[b] = 1'b0;
        end
    end

endmodule

// File: rtl/ppg_loop.sv
module ppg_loop
    import ppg_pkg::*;
#(
    parameter int NGEN = 3
) (
    input  logic [NGEN-1:0]   pulse,
    input  logic [N_LOOP-1:0] loop_en,
    input  logic [N_LOOP-1:0] ext_trig,
    output logic [N_LOOP-1:0] trig
);

    for (genvar k = 0; k < N_LOOP; k++) begin : g_trig
        if (k < NGEN) begin : g_sel
            assign trig[k] = loop_en[k] ? pulse[k] : ext_trig[k];
        end else begin : g_pass
            assign trig[k] = ext_trig[k];
        end
    end

endmodule

// File: rtl/ppg_top.sv
module ppg_top
    import ppg_pkg::*;
#(
    parameter int NGEN = 3,
    parameter int CW   = 32,
    parameter int PW   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               alarm1_i,
    input  logic [PW-1:0]      period_i,
    input  logic               timer_en_i,
    input  logic               start_on_alarm_i,
    input  logic               realign_dis_i,
    input  logic [1:0]         loop_en_i,
    input  logic [1:0]         ext_trig_i,
    input  logic [NGEN*CW-1:0] interval_i,
    output logic [NGEN-1:0]    pulse_o,
    output logic [7:0]         evt_o,
    output logic [1:0]         trig_o
);

    logic start_go;
    logic realign_go;

    assign start_go   = alarm1_i | ~start_on_alarm_i;
    assign realign_go = alarm1_i & ~realign_dis_i;

    for (genvar k = 0; k < NGEN; k++) begin : g_gen
        ppg_chan #(.CW(CW), .PW(PW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (timer_en_i),
            .tick       (tick_i),
            .start_go   (start_go),
            .realign_go (realign_go),
            .period     (period_i),
            .interval   (interval_i[k*CW +: CW]),
            .pulse      (pulse_o[k])
        );
    end

    ppg_evtmap #(.NGEN(NGEN)) u_evt (
        .pulse (pulse_o),
        .evt   (evt_o)
    );

    ppg_loop #(.NGEN(NGEN)) u_loop (
        .pulse    (pulse_o),
        .loop_en  (loop_en_i),
        .ext_trig (ext_trig_i),
        .trig     (trig_o)
    );

endmodule

// File: rtl/ppg_chk.sv
module ppg_chk #(
    parameter int NGEN = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_i,
    input logic            alarm1_i,
    input logic            timer_en_i,
    input logic            start_on_alarm_i,
    input logic            realign_dis_i,
    input logic [NGEN-1:0] pulse_o
);

    // independent record of whether a start condition has been seen
    logic started_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           started_q <= 1'b0;
        else if (!timer_en_i) started_q <= 1'b0;
        else if (alarm1_i || !start_on_alarm_i) started_q <= 1'b1;
    end

    for (genvar k = 0; k < NGEN; k++) begin : g_prop
        p_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[k] |-> $past(tick_i));
        p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(timer_en_i) |-> !pulse_o[k]);
        p_no_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pulse_o[k] |-> $past(started_q));
        p_realign_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $past(alarm1_i && timer_en_i && !realign_dis_i) |-> !pulse_o[k]);
    end

endmodule

bind ppg_top ppg_chk #(.NGEN(NGEN)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .tick_i           (tick_i),
    .alarm1_i         (alarm1_i),
    .timer_en_i       (timer_en_i),
    .start_on_alarm_i (start_on_alarm_i),
    .realign_dis_i    (realign_dis_i),
    .pulse_o          (pulse_o)
);

// File: tb/sim_ppg_top.sv
`timescale 1ns/1ps
module sim_ppg_top;

    localparam int NGEN = 3;
    localparam int CW   = 32;
    localparam int PW   = 10;
    localparam int NVEC = 15;

    // entry: {tick, alarm, expected pulse[2:0]}
    localparam logic [4:0] VEC [0:NVEC-1] = '{
        5'b10_000, 5'b01_000, 5'b10_111, 5'b10_000, 5'b10_010,
        5'b00_000, 5'b10_001, 5'b10_010, 5'b11_000, 5'b10_111,
        5'b10_000, 5'b10_010, 5'b10_001, 5'b10_010, 5'b10_100
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               tick, alarm, en, fs, frd;
    logic [PW-1:0]      period;
    logic [1:0]         lb, ext;
    logic [NGEN*CW-1:0] ivl;
    logic [NGEN-1:0]    pulse;
    logic [7:0]         evt;
    logic [1:0]         trig;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    ppg_top #(.NGEN(NGEN), .CW(CW), .PW(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .alarm1_i(alarm),
        .period_i(period), .timer_en_i(en), .start_on_alarm_i(fs),
        .realign_dis_i(frd), .loop_en_i(lb), .ext_trig_i(ext),
        .interval_i(ivl), .pulse_o(pulse), .evt_o(evt), .trig_o(trig)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic t, input logic a);
        @(negedge clk);
        tick  = t;
        alarm = a;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 0; alarm = 0; en = 0; fs = 1; frd = 0;
        period = 10'd4; lb = 2'b01; ext = 2'b10;
        ivl = {32'd20, 32'd8, 32'd12};
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 pulse", 32'(pulse), 32'd0);
        check("R1 evt", 32'(evt), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b1;
        step(0, 0);
        check("R1 idle after reset", 32'(pulse), 32'd0);

        // table walk: R2 (entry 0), R4 spacing, R6 (entry 8), R10, R11
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][4], VEC[i][3]);
            check((i == 8) ? "R6 realign same-cycle tick" : "R4 pulse pattern",
                  32'(pulse), 32'(VEC[i][2:0]));
            check("R10 event field", 32'(evt),
                  32'({VEC[i][0], VEC[i][1], VEC[i][2], 5'b00000}));
            check("R11 loopback", 32'(trig), 32'({ext[1], VEC[i][0]}));
        end

        // R7: realign disabled, alarm ignored, tick counted
        frd = 1'b1;
        step(1, 1);
        check("R7 alarm ignored", 32'(pulse), 32'b011);

        // R8: new interval takes effect at reload; R5: one clock wide
        frd = 1'b0;
        ivl[CW-1:0] = 32'd4;
        step(1, 0);
        check("R8 old count 12->8", 32'(pulse[0]), 32'd0);
        step(0, 0);
        step(1, 0);
        check("R8 old count 8->4", 32'(pulse[0]), 32'd0);
        step(1, 0);
        check("R8 reload pulse", 32'(pulse[0]), 32'd1);
        step(0, 0);
        check("R5 one clock wide", 32'(pulse[0]), 32'd0);
        step(1, 0);
        check("R8 new interval each tick", 32'(pulse[0]), 32'd1);

        // R9: disable, then re-enable waits for alarm (R2)
        en = 1'b0;
        step(1, 0);
        check("R9 disabled quiet", 32'(pulse), 32'd0);
        en = 1'b1;
        for (int j = 0; j < 3; j++) begin
            step(1, 0);
            check("R2 waits for alarm", 32'(pulse), 32'd0);
        end
        step(0, 1);
        check("R9 alarm primes", 32'(pulse), 32'd0);
        step(1, 0);
        check("R4 first pulse after alarm", 32'(pulse), 32'b111);

        // R3: start-on-alarm clear starts without alarm
        en = 1'b0;
        step(0, 0);
        en = 1'b1;
        fs = 1'b0;
        step(1, 0);
        check("R3 start cycle no pulse", 32'(pulse), 32'd0);
        step(1, 0);
        check("R3 first pulse without alarm", 32'(pulse), 32'b111);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule